// File: doc/BRIEF.md
# Stimulation Channel Command Decoder

This block is the command front end of a multichannel neural stimulator. A host shifts command frames into it over an SPI slave port (mode 0, most significant bit first, one frame per chip-select low window). The block keeps a configuration record for each of eight channels: electrode pair, duty value that sets amplitude, phase length, interphase delay, number of biphasic pulses, and first-phase polarity. It also keeps one run flag per channel, which the pulse sequencers read.

The SPI pins are sampled in the system clock domain. A completed frame is held as a single pending command until the next rising edge of a slow command clock. The command is decoded and applied only at that edge. Frames that are too short or carry an unknown opcode are dropped, and an error flag reports this.

Top module: `stim_cmd_ctrl`

## Requirements
- R1: After reset every run flag is 0, the error flag is 0 and every channel record on `chan_cfg` is all zeros.
- R2: A frame is opcode (3 bits), then channel index (3 bits), then for an edit the fields anode (4), cathode (4), duty (6), phase length (8), interphase delay (8), pulse count (8) and polarity (1), all most significant bit first. An edit stores these 39 bits as channel c's record at `chan_cfg[c*39 +: 39]`, with the anode in the top bits and the polarity in bit 0.
- R3: Opcodes are 1 = edit, 2 = start one channel, 3 = stop one channel, 4 = start all loaded channels, 5 = stop all channels. Opcodes 0, 6 and 7 are unknown.
- R4: Start-one sets the run flag of the addressed channel only. Stop-one clears the run flag of the addressed channel only.
- R5: Start-all sets the run flag of each channel that has received an accepted edit since reset. It leaves the flags of all other channels unchanged.
- R6: Stop-all clears every run flag.
- R7: A received frame changes nothing until the next rising edge of `cmd_clk`. A command clock edge with no pending frame changes nothing.
- R8: A frame with fewer bits than its opcode needs (45 for an edit, 6 otherwise), or with an unknown opcode, is discarded and sets `cmd_err`. An accepted command clears `cmd_err`.
- R9: An edit, including the rewrite of a channel that is running, leaves every run flag unchanged.
- R10: Bits clocked in beyond the length the opcode needs are ignored.
- R11: If several frames arrive before one command clock edge, only the last one is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_clk | input | 1 | Slow command clock; its rising edge applies the pending frame |
| spi_sclk | input | 1 | SPI serial clock, data sampled on its rising edge |
| spi_cs_n | input | 1 | SPI chip select, active low, frames one command |
| spi_mosi | input | 1 | SPI serial data in |
| run_flags | output | 8 | Per-channel run flags for the pulse sequencers |
| cmd_err | output | 1 | Last executed frame was discarded |
| chan_cfg | output | 312 | Eight 39-bit channel records, channel 0 in the low bits |

## Verification
The hardest condition to produce is the interaction between the SPI framing and the slow command edge. Examples are two frames queued behind one edge, an edge with nothing pending, and a frame whose bit count falls one short of an edit. The bench drives chip select and the serial clock directly, so it can cut a frame at any bit count or pad it with extra bits. It can also send frames back to back without pulsing `cmd_clk` between them. Run flags are checked between frame end and the edge, and again after the edge.

// File: rtl/stim_cmd_pkg.sv
package stim_cmd_pkg;
    localparam int NCH     = 8;
    localparam int CH_W    = 3;
    localparam int OP_W    = 3;
    localparam int EL_W    = 4;
    localparam int DUTY_W  = 6;
    localparam int TIME_W  = 8;
    localparam int CFG_W   = 2 * EL_W + DUTY_W + 3 * TIME_W + 1;
    localparam int HDR_W   = OP_W + CH_W;
    localparam int FRAME_W = HDR_W + CFG_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [OP_W-1:0] OP_EDIT      = 3'd1;
    localparam logic [OP_W-1:0] OP_START     = 3'd2;
    localparam logic [OP_W-1:0] OP_STOP      = 3'd3;
    localparam logic [OP_W-1:0] OP_START_ALL = 3'd4;
    localparam logic [OP_W-1:0] OP_STOP_ALL  = 3'd5;

    typedef struct packed {
        logic [EL_W-1:0]   anode;
        logic [EL_W-1:0]   cathode;
        logic [DUTY_W-1:0] duty;
        logic [TIME_W-1:0] phase_len;
        logic [TIME_W-1:0] gap_len;
        logic [TIME_W-1:0] pulses;
        logic              first_pol;
    } chan_cfg_t;
endpackage

// File: rtl/stim_spi_rx.sv
module stim_spi_rx
    import stim_cmd_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    output logic          frame_vld,
    output logic [FW-1:0] frame_bits,
    output logic [CW-1:0] frame_cnt
);
    typedef struct packed {
        logic [2:0]    sclk_s;
        logic [2:0]    cs_s;
        logic [1:0]    mosi_s;
        logic [FW-1:0] shreg;
        logic [CW-1:0] cnt;
        logic          vld;
    } st_t;

    st_t q, d;
    logic sclk_rise, cs_fall, cs_rise, cs_low;

    always_comb begin
        d         = q;
        d.sclk_s  = {q.sclk_s[1:0], sclk};
        d.cs_s    = {q.cs_s[1:0], cs_n};
        d.mosi_s  = {q.mosi_s[0], mosi};
        d.vld     = 1'b0;
        sclk_rise = q.sclk_s[1] & ~q.sclk_s[2];
        cs_fall   = ~q.cs_s[1] & q.cs_s[2];
        cs_rise   = q.cs_s[1] & ~q.cs_s[2];
        cs_low    = ~q.cs_s[1];
        if (cs_fall) begin
            d.cnt   = '0;
            d.shreg = '0;
        end else if (cs_low && sclk_rise && (q.cnt < CW'(FW))) begin
            d.shreg[CW'(FW - 1) - q.cnt] = q.mosi_s[1];
            d.cnt = q.cnt + 1'b1;
        end
        if (cs_rise) d.vld = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs_s   <= 3'b111;
        end else begin
            q <= d;
        end
    end

    assign frame_vld  = q.vld;
    assign frame_bits = q.shreg;
    assign frame_cnt  = q.cnt;

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(FW));
endmodule

// File: rtl/stim_cmd_decode.sv
module stim_cmd_decode
    import stim_cmd_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_clk,
    input  logic             frame_vld,
    input  logic [FW-1:0]    frame_bits,
    input  logic [CW-1:0]    frame_cnt,
    output logic             exec,
    output logic [OP_W-1:0]  op,
    output logic [CH_W-1:0]  ch,
    output chan_cfg_t        cfg,
    output logic             err
);
    typedef struct packed {
        logic [2:0]      tick_s;
        logic            pend;
        logic [FW-1:0]   pbits;
        logic [CW-1:0]   pcnt;
        logic            exec;
        logic [OP_W-1:0] op;
        logic [CH_W-1:0] ch;
        chan_cfg_t       cfg;
        logic            err;
    } st_t;

    st_t q, d;
    logic            tick_rise, known, long_enough;
    logic [OP_W-1:0] opc;

    always_comb begin
        d           = q;
        d.tick_s    = {q.tick_s[1:0], cmd_clk};
        d.exec      = 1'b0;
        tick_rise   = q.tick_s[1] & ~q.tick_s[2];
        opc         = q.pbits[FW-1 -: OP_W];
        known       = (opc >= OP_EDIT) && (opc <= OP_STOP_ALL);
        long_enough = (opc == OP_EDIT) ? (q.pcnt >= CW'(FW)) : (q.pcnt >= CW'(HDR_W));
        if (tick_rise && q.pend) begin
            d.pend = 1'b0;
            if (known && long_enough) begin
                d.exec = 1'b1;
                d.op   = opc;
                d.ch   = q.pbits[FW-OP_W-1 -: CH_W];
                d.cfg  = chan_cfg_t'(q.pbits[CFG_W-1:0]);
                d.err  = 1'b0;
            end else begin
                d.err  = 1'b1;
            end
        end
        if (frame_vld) begin
            d.pend  = 1'b1;
            d.pbits = frame_bits;
            d.pcnt  = frame_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign exec = q.exec;
    assign op   = q.op;
    assign ch   = q.ch;
    assign cfg  = q.cfg;
    assign err  = q.err;

    p_err_at_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_rise && q.pend) |=> $stable(q.err));
    p_exec_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.exec |-> (q.op >= OP_EDIT && q.op <= OP_STOP_ALL));
endmodule

// File: rtl/stim_chan_mem.sv
module stim_chan_mem
    import stim_cmd_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic [CH_W-1:0]    ch_i,
    input  chan_cfg_t          cfg_i,
    output logic [N-1:0]       run_o,
    output logic [N*CFG_W-1:0] cfg_o
);
    typedef struct packed {
        chan_cfg_t [N-1:0] cfg;
        logic [N-1:0]      loaded;
        logic [N-1:0]      run;
    } st_t;

    st_t q, d;
    logic [N-1:0] sel;

    always_comb begin
        d        = q;
        sel      = '0;
        sel[ch_i] = 1'b1;
        if (exec_i) begin
            case (op_i)
                OP_EDIT: begin
                    d.cfg[ch_i] = cfg_i;
                    d.loaded    = q.loaded | sel;
                end
                OP_START:     d.run = q.run | sel;
                OP_STOP:      d.run = q.run & ~sel;
                OP_START_ALL: d.run = q.run | q.loaded;
                OP_STOP_ALL:  d.run = '0;
                default:      d.run = q.run;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run_o = q.run;
    for (genvar i = 0; i < N; i++) begin : g_cfg
        assign cfg_o[i*CFG_W +: CFG_W] = q.cfg[i];
    end

    p_run_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(q.run));
    p_stop_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_STOP_ALL) |=> (q.run == '0));
    p_start_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_START_ALL) |=>
            ((q.run & ~q.loaded) == $past(q.run & ~q.loaded)));
    p_edit_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_EDIT) |=> $stable(q.run));
endmodule

// File: rtl/stim_cmd_ctrl.sv
module stim_cmd_ctrl
    import stim_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_clk,
    input  logic                 spi_sclk,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic [NCH-1:0]       run_flags,
    output logic                 cmd_err,
    output logic [NCH*CFG_W-1:0] chan_cfg
);
    logic                 f_vld;
    logic [FRAME_W-1:0]   f_bits;
    logic [CNT_W-1:0]     f_cnt;
    logic                 x_exec;
    logic [OP_W-1:0]      x_op;
    logic [CH_W-1:0]      x_ch;
    chan_cfg_t            x_cfg;

    stim_spi_rx #(.FW(FRAME_W), .CW(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .frame_vld(f_vld), .frame_bits(f_bits), .frame_cnt(f_cnt)
    );

    stim_cmd_decode #(.FW(FRAME_W), .CW(CNT_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_clk(cmd_clk),
        .frame_vld(f_vld), .frame_bits(f_bits), .frame_cnt(f_cnt),
        .exec(x_exec), .op(x_op), .ch(x_ch), .cfg(x_cfg), .err(cmd_err)
    );

    stim_chan_mem #(.N(NCH)) u_mem (
        .clk(clk), .rst_n(rst_n), .exec_i(x_exec), .op_i(x_op), .ch_i(x_ch),
        .cfg_i(x_cfg), .run_o(run_flags), .cfg_o(chan_cfg)
    );
endmodule

// File: tb/stim_cmd_ctrl_tb.sv
module stim_cmd_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_clk = 1'b0;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         mosi = 1'b0;
    logic [7:0]   run_flags;
    logic         cmd_err;
    logic [311:0] chan_cfg;
    int           checks = 0;
    int           failures = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    stim_cmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_clk(cmd_clk), .spi_sclk(sclk),
        .spi_cs_n(cs_n), .spi_mosi(mosi), .run_flags(run_flags),
        .cmd_err(cmd_err), .chan_cfg(chan_cfg)
    );

    // entry: {nbits[59:54], frame[53:9], exp_run[8:1], exp_err[0]}
    localparam int NV = 14;
    localparam logic [59:0] VEC [NV] = '{
        {6'd45, 3'd1, 3'd3, 4'd1, 4'd2, 6'd20, 8'd10, 8'd5, 8'd3, 1'b1, 8'h00, 1'b0}, // R2 R9
        {6'd45, 3'd1, 3'd5, 4'd7, 4'd9, 6'd63, 8'd200, 8'd1, 8'd255, 1'b0, 8'h00, 1'b0},
        {6'd6,  3'd2, 3'd0, 39'd0, 8'h01, 1'b0},  // R4 start one
        {6'd6,  3'd4, 3'd0, 39'd0, 8'h29, 1'b0},  // R5 start all
        {6'd6,  3'd3, 3'd3, 39'd0, 8'h21, 1'b0},  // R4 stop one
        {6'd6,  3'd7, 3'd2, 39'd0, 8'h21, 1'b1},  // R8 unknown op
        {6'd5,  3'd2, 3'd6, 39'd0, 8'h21, 1'b1},  // R8 short
        {6'd6,  3'd5, 3'd0, 39'd0, 8'h00, 1'b0},  // R6 stop all
        {6'd44, 3'd1, 3'd1, 4'd3, 4'd4, 6'd5, 8'd6, 8'd7, 8'd8, 1'b1, 8'h00, 1'b1}, // R8 short edit
        {6'd10, 3'd2, 3'd7, 39'd0, 8'h80, 1'b0},  // R10 extra bits
        {6'd6,  3'd4, 3'd0, 39'd0, 8'hA8, 1'b0},  // R5 ch1 not loaded
        {6'd45, 3'd1, 3'd3, 4'd15, 4'd0, 6'd33, 8'd77, 8'd2, 8'd9, 1'b0, 8'hA8, 1'b0}, // R9 rewrite
        {6'd6,  3'd0, 3'd0, 39'd0, 8'hA8, 1'b1},  // R3 opcode 0 unknown
        {6'd6,  3'd5, 3'd0, 39'd0, 8'h00, 1'b0}   // R6
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input int nbits, input logic [44:0] bits);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 45) ? bits[44 - i] : 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic tick();
        cmd_clk = 1'b1;
        repeat (12) @(negedge clk);
        cmd_clk = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [38:0] rec(input int c);
        return chan_cfg[c*39 +: 39];
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(run_flags == 8'h00, "R1 run", 64'(run_flags), 64'h0);
        check(cmd_err == 1'b0, "R1 err", 64'(cmd_err), 64'h0);
        check(chan_cfg == '0, "R1 cfg", 64'(chan_cfg[63:0]), 64'h0);

        for (int v = 0; v < NV; v++) begin
            send(int'(VEC[v][59:54]), VEC[v][53:9]);
            tick();
            check(run_flags == VEC[v][8:1], $sformatf("R4/R5/R6 run vec%0d", v),
                  64'(run_flags), 64'(VEC[v][8:1]));
            check(cmd_err == VEC[v][0], $sformatf("R8 err vec%0d", v),
                  64'(cmd_err), 64'(VEC[v][0]));
        end
        // R2 record layout and R9 rewrite
        check(rec(3) == {4'd15, 4'd0, 6'd33, 8'd77, 8'd2, 8'd9, 1'b0}, "R2 ch3",
              64'(rec(3)), 64'({4'd15, 4'd0, 6'd33, 8'd77, 8'd2, 8'd9, 1'b0}));
        check(rec(5) == {4'd7, 4'd9, 6'd63, 8'd200, 8'd1, 8'd255, 1'b0}, "R2 ch5",
              64'(rec(5)), 64'({4'd7, 4'd9, 6'd63, 8'd200, 8'd1, 8'd255, 1'b0}));
        check(rec(1) == '0, "R8 short edit not stored", 64'(rec(1)), 64'h0);

        // R7: nothing happens before the command edge
        send(6, {3'd2, 3'd5, 39'd0});
        check(run_flags == 8'h00, "R7 before edge", 64'(run_flags), 64'h0);
        tick();
        check(run_flags == 8'h20, "R7 after edge", 64'(run_flags), 64'h20);

        // R11: two frames, one edge, last wins
        send(6, {3'd2, 3'd2, 39'd0});
        send(6, {3'd2, 3'd4, 39'd0});
        tick();
        check(run_flags == 8'h30, "R11 last frame only", 64'(run_flags), 64'h30);
        tick();
        check(run_flags == 8'h30, "R7 empty edge", 64'(run_flags), 64'h30);
        check(cmd_err == 1'b0, "R7 empty edge err", 64'(cmd_err), 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule